// File: doc/BRIEF.md
# Legacy Instruction-Set Entry Branch Checker

This block evaluates the branch that moves a core from its native instruction set into a legacy 32-bit instruction set. When a request strobe arrives, it checks the branch for faults and computes the legacy instruction pointer from the target branch register and the code-segment base. It also produces the updated processor status word.

Faults come in two groups. Faults on the branch itself (illegal qualifying predicate, transitions disabled) stop the transition. Segment and floating-point faults do not stop the transition. They are flagged for the first legacy instruction.

The block is a two-state machine. In `ST_IDLE` it waits. The transition IDLE->RESP fires on an accepted `req_valid` and captures all results. `ST_RESP` drives the `done` pulse for one cycle. The transition RESP->IDLE is unconditional. Results stay on the outputs until the next accepted request.

Status word layout (`stat_in`/`stat_out`, 9 bits):

| Bits | Meaning |
|------|---------|
| [0] | legacy-mode bit |
| [5:1] | five debug / access-control bits |
| [6] | register-bank select |
| [8:7] | privilege level |

Top module: `isx_branch_check`

## Requirements
- R1: After reset, `done` is 0. Every result output (`new_ip`, `stat_out`, `taken` and all four fault flags) is 0, and the machine is in `ST_IDLE`.
- R2: A `req_valid` seen at a clock edge while in `ST_IDLE` is accepted. At the next clock edge the results are valid and `done` is 1 for exactly one cycle.
- R3: A `req_valid` seen while in `ST_RESP` is ignored. No `done` follows it, and the outputs keep the previous request's results.
- R4: If `qual_pred` is not 0, `flt_illegal` is 1 and no transition occurs. In that case `taken`=0, `new_ip`=0 and `stat_out` equals `stat_in`.
- R5: If `qual_pred` is 0 and `xfer_dis` is 1, `flt_xdis` is 1 and no transition occurs, with the same outputs as in R4. `flt_xdis` is never 1 together with `flt_illegal`.
- R6: When neither branch fault occurs, `taken`=1 and `new_ip` equals `tgt_reg[31:0]` minus `seg_base`, modulo 2^32. This holds at any privilege level.
- R7: On a taken transition, `flt_gp_tgt` is 1 if `new_ip` > `seg_limit` or if `seg_priv_viol` is 1. An ip equal to the limit does not fault.
- R8: On a taken transition with `seg_16` = 1, `flt_gp_tgt` is 1 if `new_ip` >= 65536.
- R9: On a taken transition, `flt_fp_tgt` equals `fp_dis`.
- R10: On a taken transition, `stat_out` bit 0 is 1 and bits [5:1] are 0. Bits [8:6] (bank select and privilege) always equal `stat_in`.
- R11: When a branch fault occurs, `flt_gp_tgt` and `flt_fp_tgt` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request strobe |
| qual_pred | input | PRED_W (6) | qualifying predicate index |
| tgt_reg | input | TGT_W (64) | target branch register |
| seg_base | input | IP_W (32) | code-segment base |
| seg_limit | input | IP_W (32) | code-segment limit |
| seg_16 | input | 1 | target segment is 16-bit |
| seg_priv_viol | input | 1 | segment privilege violation present |
| xfer_dis | input | 1 | instruction-set transitions disabled |
| fp_dis | input | 1 | floating-point registers disabled |
| stat_in | input | 9 | current status word |
| done | output | 1 | one-cycle result pulse |
| taken | output | 1 | transition performed |
| new_ip | output | IP_W (32) | legacy instruction pointer |
| stat_out | output | 9 | updated status word |
| flt_illegal | output | 1 | illegal-operation fault on the branch |
| flt_xdis | output | 1 | transition-disabled fault on the branch |
| flt_gp_tgt | output | 1 | general-protection fault on the first target instruction |
| flt_fp_tgt | output | 1 | FP-disabled fault on the first target instruction |

## Verification
Random requests are drawn with the predicate index mostly zero and the disable bits set with low probability. This mix exercises the fault priority (illegal before disabled) and the suppression of deferred faults.

Directed cases cover four boundaries:
- the ip exactly at the limit versus one past it;
- an ip of 65535 versus 65536 in a 16-bit segment;
- a target below the base, where the subtraction wraps;
- a request held high during the response cycle, which shows whether it is ignored.

// File: rtl/isx_pkg.sv
package isx_pkg;
    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RESP = 1'b1} isx_state_t;

    localparam int STAT_W   = 9;
    localparam int ISA_BIT  = 0;
    localparam int KEEP_LO  = 6;
    localparam logic [STAT_W-1:0] ISA_MASK = 9'b0_0000_0001;
    localparam logic [STAT_W-1:0] CLR_MASK = 9'b0_0011_1110;
endpackage

// File: rtl/isx_ip_calc.sv
module isx_ip_calc #(
    parameter int TGT_W   = 64,
    parameter int IP_W    = 32,
    parameter int WIN16_W = 16
) (
    input  logic [TGT_W-1:0] tgt,
    input  logic [IP_W-1:0]  base,
    input  logic [IP_W-1:0]  limit,
    output logic [IP_W-1:0]  ip,
    output logic             over_limit,
    output logic             out_win16
);
    always_comb begin
        ip         = tgt[IP_W-1:0] - base;
        over_limit = ip > limit;
        out_win16  = |ip[IP_W-1:WIN16_W];
    end
endmodule

// File: rtl/isx_fault_eval.sv
module isx_fault_eval #(
    parameter int PRED_W = 6
) (
    input  logic [PRED_W-1:0] qual_pred,
    input  logic              xfer_dis,
    input  logic              fp_dis,
    input  logic              seg_bad,
    output logic              illegal,
    output logic              xdis,
    output logic              gp,
    output logic              fpd,
    output logic              taken
);
    always_comb begin
        illegal = |qual_pred;
        xdis    = !illegal && xfer_dis;
        taken   = !illegal && !xfer_dis;
        gp      = taken && seg_bad;
        fpd     = taken && fp_dis;
    end

    // R5: the two branch faults are mutually exclusive
    always_comb begin
        a_r5_branch_excl: assert ($onehot0({illegal, xdis}));
    end
endmodule

// File: rtl/isx_branch_check.sv
module isx_branch_check
    import isx_pkg::*;
#(
    parameter int PRED_W  = 6,
    parameter int TGT_W   = 64,
    parameter int IP_W    = 32,
    parameter int WIN16_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PRED_W-1:0] qual_pred,
    input  logic [TGT_W-1:0]  tgt_reg,
    input  logic [IP_W-1:0]   seg_base,
    input  logic [IP_W-1:0]   seg_limit,
    input  logic              seg_16,
    input  logic              seg_priv_viol,
    input  logic              xfer_dis,
    input  logic              fp_dis,
    input  logic [STAT_W-1:0] stat_in,
    output logic              done,
    output logic              taken,
    output logic [IP_W-1:0]   new_ip,
    output logic [STAT_W-1:0] stat_out,
    output logic              flt_illegal,
    output logic              flt_xdis,
    output logic              flt_gp_tgt,
    output logic              flt_fp_tgt
);
    isx_state_t st_q, st_d;

    logic [IP_W-1:0]   ip_c;
    logic              over_c, win_c;
    logic              ill_c, xdis_c, gp_c, fpd_c, taken_c;
    logic [STAT_W-1:0] stat_c;
    logic              accept;

    logic [IP_W-1:0]   ip_q;
    logic [STAT_W-1:0] stat_q, stat_in_q;
    logic              ill_q, xdis_q, gp_q, fpd_q, taken_q;

    isx_ip_calc #(.TGT_W(TGT_W), .IP_W(IP_W), .WIN16_W(WIN16_W)) u_calc (
        .tgt        (tgt_reg),
        .base       (seg_base),
        .limit      (seg_limit),
        .ip         (ip_c),
        .over_limit (over_c),
        .out_win16  (win_c)
    );

    isx_fault_eval #(.PRED_W(PRED_W)) u_flt (
        .qual_pred (qual_pred),
        .xfer_dis  (xfer_dis),
        .fp_dis    (fp_dis),
        .seg_bad   (over_c || seg_priv_viol || (seg_16 && win_c)),
        .illegal   (ill_c),
        .xdis      (xdis_c),
        .gp        (gp_c),
        .fpd       (fpd_c),
        .taken     (taken_c)
    );

    assign accept = (st_q == ST_IDLE) && req_valid;
    assign stat_c = taken_c ? ((stat_in & ~CLR_MASK) | ISA_MASK) : stat_in;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (req_valid) st_d = ST_RESP;
            ST_RESP: st_d = ST_IDLE;
        endcase
    end

    // result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q      <= '0;
            stat_q    <= '0;
            stat_in_q <= '0;
            ill_q     <= 1'b0;
            xdis_q    <= 1'b0;
            gp_q      <= 1'b0;
            fpd_q     <= 1'b0;
            taken_q   <= 1'b0;
        end else if (accept) begin
            ip_q      <= taken_c ? ip_c : '0;
            stat_q    <= stat_c;
            stat_in_q <= stat_in;
            ill_q     <= ill_c;
            xdis_q    <= xdis_c;
            gp_q      <= gp_c;
            fpd_q     <= fpd_c;
            taken_q   <= taken_c;
        end
    end

    // outputs
    always_comb begin
        done        = (st_q == ST_RESP);
        taken       = taken_q;
        new_ip      = ip_q;
        stat_out    = stat_q;
        flt_illegal = ill_q;
        flt_xdis    = xdis_q;
        flt_gp_tgt  = gp_q;
        flt_fp_tgt  = fpd_q;
    end

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r3_resp_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RESP) |=> (st_q == ST_IDLE) && $stable(new_ip) && $stable(stat_out));
    a_r10_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> stat_out[STAT_W-1:KEEP_LO] == stat_in_q[STAT_W-1:KEEP_LO]);
    a_r10_isa_set: assert property (@(posedge clk) disable iff (!rst_n)
        (done && taken) |-> stat_out[ISA_BIT] && ((stat_out & CLR_MASK) == '0));
    a_r11_no_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (flt_illegal || flt_xdis)) |-> !flt_gp_tgt && !flt_fp_tgt && !taken);
    a_r4_no_xfer_status: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !taken) |-> (stat_out == stat_in_q) && (new_ip == '0));
endmodule

// File: tb/tb_isx_branch_check.sv
module tb_isx_branch_check;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  qual_pred = '0;
    logic [63:0] tgt_reg = '0;
    logic [31:0] seg_base = '0, seg_limit = '0;
    logic        seg_16 = 1'b0, seg_priv_viol = 1'b0, xfer_dis = 1'b0, fp_dis = 1'b0;
    logic [8:0]  stat_in = '0;
    logic        done, taken, flt_illegal, flt_xdis, flt_gp_tgt, flt_fp_tgt;
    logic [31:0] new_ip;
    logic [8:0]  stat_out;

    int n_chk = 0, n_bad = 0;

    isx_branch_check dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .qual_pred(qual_pred),
        .tgt_reg(tgt_reg), .seg_base(seg_base), .seg_limit(seg_limit),
        .seg_16(seg_16), .seg_priv_viol(seg_priv_viol), .xfer_dis(xfer_dis),
        .fp_dis(fp_dis), .stat_in(stat_in), .done(done), .taken(taken),
        .new_ip(new_ip), .stat_out(stat_out), .flt_illegal(flt_illegal),
        .flt_xdis(flt_xdis), .flt_gp_tgt(flt_gp_tgt), .flt_fp_tgt(flt_fp_tgt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // expected results: {taken, ill, xdis, gp, fp, ip[31:0], stat[8:0]}
    logic        e_tk, e_il, e_xd, e_gp, e_fp;
    logic [31:0] e_ip;
    logic [8:0]  e_st;

    task automatic model();
        logic [31:0] ip;
        ip   = tgt_reg[31:0] - seg_base;
        e_il = (qual_pred != 0);
        e_xd = !e_il && xfer_dis;
        e_tk = !e_il && !xfer_dis;
        e_gp = e_tk && ((ip > seg_limit) || seg_priv_viol || (seg_16 && ip >= 32'h1_0000));
        e_fp = e_tk && fp_dis;
        e_ip = e_tk ? ip : 32'd0;
        e_st = e_tk ? {stat_in[8:6], 5'b0, 1'b1} : stat_in;
    endtask

    task automatic check_results();
        chk("R2 done", done, 1);
        chk("R4 illegal", flt_illegal, e_il);
        chk("R5 xdis", flt_xdis, e_xd);
        chk("R6 taken", taken, e_tk);
        chk("R6 new_ip", new_ip, e_ip);
        chk("R7 R8 gp", flt_gp_tgt, e_gp);
        chk("R9 fp", flt_fp_tgt, e_fp);
        chk("R10 stat", stat_out, e_st);
        if (!e_tk) chk("R11 no deferred", {flt_gp_tgt, flt_fp_tgt}, 0);
    endtask

    task automatic issue(input logic [5:0] p, input logic [63:0] t, input logic [31:0] b,
                         input logic [31:0] l, input logic s16, input logic pv,
                         input logic xd, input logic fd, input logic [8:0] st);
        @(negedge clk);
        qual_pred = p; tgt_reg = t; seg_base = b; seg_limit = l; seg_16 = s16;
        seg_priv_viol = pv; xfer_dis = xd; fp_dis = fd; stat_in = st;
        req_valid = 1'b1;
        model();
        @(negedge clk);
        req_valid = 1'b0;
        check_results();
        @(negedge clk);
        chk("R2 done single pulse", done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", done, 0);
        chk("R1 outputs", {taken, flt_illegal, flt_xdis, flt_gp_tgt, flt_fp_tgt, new_ip, stat_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle no done", done, 0);

        // directed corners
        issue(6'd0, 64'hFFFF_0000_0000_1100, 32'h100, 32'h1000, 0, 0, 0, 0, 9'h1FE); // R6 R7 ip==limit
        issue(6'd0, 64'h1101, 32'h100, 32'h1000, 0, 0, 0, 0, 9'h0AA);               // R7 limit+1
        issue(6'd0, 64'h2_FFFF, 32'h2_0000, 32'hFFFF_FFFF, 1, 0, 0, 0, 9'h155);    // R8 65535 ok
        issue(6'd0, 64'h3_0000, 32'h2_0000, 32'hFFFF_FFFF, 1, 0, 0, 0, 9'h155);    // R8 65536 gp
        issue(6'd0, 64'h10, 32'h20, 32'hFFFF_FFFF, 0, 0, 0, 1, 9'h180);            // R6 wrap, R9
        issue(6'd0, 64'h500, 32'h0, 32'hFFFF, 0, 1, 0, 0, 9'h1C0);                 // R7 priv viol
        issue(6'd3, 64'h500, 32'h0, 32'h10, 1, 1, 1, 1, 9'h03E);                   // R4 R11
        issue(6'd0, 64'h500, 32'h0, 32'h10, 1, 1, 1, 1, 9'h03E);                   // R5 R11

        // R3: request held during response cycle is ignored
        @(negedge clk);
        qual_pred = 0; tgt_reg = 64'h4000; seg_base = 32'h1000; seg_limit = 32'hFFFF;
        seg_16 = 0; seg_priv_viol = 0; xfer_dis = 0; fp_dis = 0; stat_in = 9'h03E;
        req_valid = 1'b1; model();
        @(negedge clk);
        check_results();
        qual_pred = 6'd9; tgt_reg = 64'h9999; stat_in = 9'h1FF;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 no done after ignored req", done, 0);
        chk("R3 new_ip held", new_ip, e_ip);
        chk("R3 illegal held", flt_illegal, e_il);
        chk("R3 stat held", stat_out, e_st);

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [31:0] b, l;
            logic [63:0] t;
            logic s16;
            b   = $urandom();
            s16 = ($urandom() % 4) == 0;
            t   = {$urandom(), b + (s16 ? ($urandom() % 32'h2_0000) : $urandom())};
            l   = (($urandom() % 2) == 0) ? t[31:0] - b + ($urandom() % 3) - 1 : $urandom();
            issue((($urandom() % 5) == 0) ? 6'($urandom()) : 6'd0, t, b, l, s16,
                  ($urandom() % 8) == 0, ($urandom() % 6) == 0, ($urandom() % 4) == 0,
                  9'($urandom()));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule